// File: doc/BRIEF.md
# NAND Flash Instruction Sequencer

This block runs a short program of NAND operations that software loads into a handful of registers. The program is up to seven 6-bit opcodes packed into two instruction words. It is supported by four command bytes, a row address, a column address, a byte count and a wait limit. A write to the start register launches the program. The engine then steps through the opcode slots in order. For each opcode it issues a command byte, address bytes or data reads on an abstract NAND bus, which carries separate command-latch, address-latch and read strobes, an 8-bit data output, an 8-bit data input and a ready input.

Read bytes go out through a buffer write port. Their addresses start at the column offset and are moved up by one page when the spare-area bit of the column register is set. When the program ends, the status register reports completion. A wait for ready that outlasts the programmed limit stops the program and reports a timeout together with completion. Software clears each status flag by writing a 1 to it.

Top module: `nand_op_sequencer`

## Requirements
- R1: Register offsets on `regAddr`: 0 command bytes, 1 row, 2 column, 3 byte count, 4 first instruction word, 5 second instruction word, 6 start, 7 status, 8 wait limit. After reset the status register reads 0, and the latch strobes and the read strobe are low.
- R2: The first instruction word holds slots 0 to 4 at bits 31:26, 25:20, 19:14, 13:8 and 7:2. The second word holds slots 5 and 6 at bits 31:26 and 25:20. Slots execute in ascending order. Opcode 0x00 ends the program, and no later slot runs.
- R3: Opcodes 0x09, 0x0A, 0x0B and 0x0C each pulse the command latch once, driving command byte 0, 1, 2 or 3 respectively. These bytes sit at bits 31:24, 23:16, 15:8 and 7:0 of the command register.
- R4: Opcodes 0x11 to 0x14 first wait until `nandRdy` is high, with no strobe issued meanwhile. They then issue command byte 0 to 3 in the same way as R3.
- R5: Opcode 0x01 sends two address-latch bytes, column bits 7:0 and then 15:8. Opcode 0x05 sends three address-latch bytes, row bits 7:0, then 15:8, then 23:16.
- R6: Opcode 0x1B waits for ready and then issues as many read strobes as the byte count, where a count of 0 means a full page of PAGE_BYTES. The k-th byte is written to buffer address base+k. The base is column bits [BUF_AW-2:0], plus PAGE_BYTES when column bit 31 (spare area) is set.
- R7: Completion sets status bit 31. For a program whose first slot is a single direct command and whose second slot is 0x00, the bit is set by the third clock edge after the edge that accepts the start write.
- R8: If a wait lasts beyond the wait-limit register value, the program stops with no further strobes, and status bits 27 (timeout) and 31 (done) are both set.
- R9: Writing a 1 to status bit 31 or bit 27 clears that bit only. Status bits 25 and 24 read 0.
- R10: A start write (bit 31 of offset 6) while a program is running has no effect on the running program.
- R11: Opcodes outside the defined set are skipped, and execution continues with the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data (status register, else 0) |
| nandCle | output | 1 | Command-latch strobe |
| nandAle | output | 1 | Address-latch strobe |
| nandRe | output | 1 | Read strobe; data sampled on the closing edge |
| nandDout | output | 8 | Command or address byte |
| nandDin | input | 8 | Data from flash |
| nandRdy | input | 1 | Flash ready (high) / busy (low) |
| bufWe | output | 1 | Buffer write enable |
| bufAddr | output | BUF_AW | Buffer write address |
| bufData | output | 8 | Buffer write data |

## Verification
Strobes appear in the cycle after the state that issues them is entered. A single command reaches the bus in the second cycle after the start edge, and the done bit rises on the third edge. A buffer write follows its read strobe by exactly one cycle, carrying the byte sampled on that strobe's closing edge. The bench counts strobes and buffer writes at every rising edge and reads status half a cycle after an edge. It checks the exact done cycle only for the single-command case, and polls for completion elsewhere before comparing counts and bytes.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  localparam int SLOTS = 7;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] REG_CMD    = 4'd0;
  localparam logic [REG_AW-1:0] REG_ROW    = 4'd1;
  localparam logic [REG_AW-1:0] REG_COL    = 4'd2;
  localparam logic [REG_AW-1:0] REG_COUNT  = 4'd3;
  localparam logic [REG_AW-1:0] REG_PROG0  = 4'd4;
  localparam logic [REG_AW-1:0] REG_PROG1  = 4'd5;
  localparam logic [REG_AW-1:0] REG_GO     = 4'd6;
  localparam logic [REG_AW-1:0] REG_STATUS = 4'd7;
  localparam logic [REG_AW-1:0] REG_LIMIT  = 4'd8;

  localparam logic [5:0] OP_NOP     = 6'h00;
  localparam logic [5:0] OP_COL     = 6'h01;
  localparam logic [5:0] OP_ROW     = 6'h05;
  localparam logic [5:0] OP_CMD_LO  = 6'h09;
  localparam logic [5:0] OP_CMD_HI  = 6'h0C;
  localparam logic [5:0] OP_WCMD_LO = 6'h11;
  localparam logic [5:0] OP_WCMD_HI = 6'h14;
  localparam logic [5:0] OP_WREAD   = 6'h1B;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_WAIT, ST_CMD, ST_ADDR, ST_READ
  } seqState_t;

  typedef struct packed {
    logic       cle;
    logic       ale;
    logic       re;
    logic       useRow;
    logic [1:0] cmdSel;
    logic       clrCnt;
    logic       incWait;
    logic       setDone;
    logic       setTimeout;
  } seqStrobe_t;
endpackage

// File: rtl/nseq_ctrl.sv
module nseq_ctrl
  import nseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [5:0] curOp,
  input  logic       nandRdy,
  input  logic       waitExpired,
  input  logic       addrLast,
  input  logic       readLast,
  output logic [2:0] slot,
  output seqStrobe_t strb
);
  seqState_t  state, nState;
  logic [2:0] nSlot;
  logic       afterRead, nAfterRead;
  logic       useRowQ, nUseRow;
  logic [1:0] cmdSelQ, nCmdSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slot      <= '0;
      afterRead <= 1'b0;
      useRowQ   <= 1'b0;
      cmdSelQ   <= '0;
    end else begin
      state     <= nState;
      slot      <= nSlot;
      afterRead <= nAfterRead;
      useRowQ   <= nUseRow;
      cmdSelQ   <= nCmdSel;
    end
  end

  always_comb begin
    strb        = '0;
    strb.useRow = useRowQ;
    strb.cmdSel = cmdSelQ;
    nState      = state;
    nSlot       = slot;
    nAfterRead  = afterRead;
    nUseRow     = useRowQ;
    nCmdSel     = cmdSelQ;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          nState = ST_DECODE;
          nSlot  = '0;
        end
      end
      ST_DECODE: begin
        strb.clrCnt = 1'b1;
        if (slot == 3'(SLOTS) || curOp == OP_NOP) begin
          strb.setDone = 1'b1;
          nState       = ST_IDLE;
        end else if (curOp == OP_COL) begin
          nUseRow = 1'b0;
          nState  = ST_ADDR;
        end else if (curOp == OP_ROW) begin
          nUseRow = 1'b1;
          nState  = ST_ADDR;
        end else if (curOp >= OP_CMD_LO && curOp <= OP_CMD_HI) begin
          nCmdSel = 2'(curOp - OP_CMD_LO);
          nState  = ST_CMD;
        end else if (curOp >= OP_WCMD_LO && curOp <= OP_WCMD_HI) begin
          nCmdSel    = 2'(curOp - OP_WCMD_LO);
          nAfterRead = 1'b0;
          nState     = ST_WAIT;
        end else if (curOp == OP_WREAD) begin
          nAfterRead = 1'b1;
          nState     = ST_WAIT;
        end else begin
          nSlot = slot + 3'd1;
        end
      end
      ST_WAIT: begin
        if (nandRdy) begin
          nState = afterRead ? ST_READ : ST_CMD;
        end else if (waitExpired) begin
          strb.setTimeout = 1'b1;
          strb.setDone    = 1'b1;
          nState          = ST_IDLE;
        end else begin
          strb.incWait = 1'b1;
        end
      end
      ST_CMD: begin
        strb.cle = 1'b1;
        nSlot    = slot + 3'd1;
        nState   = ST_DECODE;
      end
      ST_ADDR: begin
        strb.ale = 1'b1;
        if (addrLast) begin
          nSlot  = slot + 3'd1;
          nState = ST_DECODE;
        end
      end
      ST_READ: begin
        strb.re = 1'b1;
        if (readLast) begin
          nSlot  = slot + 3'd1;
          nState = ST_DECODE;
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  // R2: within one run the slot pointer never moves backwards
  a_r2_slot_forward: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> slot >= $past(slot));

  // R4: a cycle of waiting without ready is never followed by a command or read strobe
  a_r4_quiet_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_WAIT && !$past(nandRdy)) |-> !(strb.cle || strb.re));
endmodule

// File: rtl/nseq_dpath.sv
module nseq_dpath
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int WAIT_W     = 16,
  localparam int CNT_W     = $clog2(PAGE_BYTES) + 1,
  localparam int BUF_AW    = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  seqStrobe_t        strb,
  input  logic [2:0]        slot,
  output logic [5:0]        curOp,
  output logic              startReq,
  output logic              waitExpired,
  output logic              addrLast,
  output logic              readLast,
  output logic [7:0]        nandDout,
  input  logic [7:0]        nandDin,
  output logic              bufWe,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [7:0]        bufData
);
  logic [31:0]       cmdReg, rowReg, colReg, prog0, prog1;
  logic [CNT_W-1:0]  cntReg, byteIdx, readTotal;
  logic [WAIT_W-1:0] waitLim, waitCnt;
  logic              statDone, statTo;
  logic [5:0]        ops [8];
  logic [BUF_AW-1:0] colBase;

  function automatic logic wrAt(input logic [REG_AW-1:0] a);
    return regWrEn && regAddr == a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      rowReg  <= '0;
      colReg  <= '0;
      cntReg  <= '0;
      prog0   <= '0;
      prog1   <= '0;
      waitLim <= '0;
    end else begin
      if (wrAt(REG_CMD))   cmdReg  <= regWrData;
      if (wrAt(REG_ROW))   rowReg  <= regWrData;
      if (wrAt(REG_COL))   colReg  <= regWrData;
      if (wrAt(REG_COUNT)) cntReg  <= regWrData[CNT_W-1:0];
      if (wrAt(REG_PROG0)) prog0   <= regWrData;
      if (wrAt(REG_PROG1)) prog1   <= regWrData;
      if (wrAt(REG_LIMIT)) waitLim <= regWrData[WAIT_W-1:0];
    end
  end

  assign startReq = wrAt(REG_GO) && regWrData[31];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statDone <= 1'b0;
      statTo   <= 1'b0;
    end else begin
      if (strb.setDone) statDone <= 1'b1;
      else if (wrAt(REG_STATUS) && regWrData[31]) statDone <= 1'b0;
      if (strb.setTimeout) statTo <= 1'b1;
      else if (wrAt(REG_STATUS) && regWrData[27]) statTo <= 1'b0;
    end
  end

  assign regRdData = (regAddr == REG_STATUS) ? {statDone, 3'b000, statTo, 27'd0} : 32'd0;

  for (genvar g = 0; g < 8; g++) begin : g_slot
    if (g < 5) begin : g_w0
      assign ops[g] = prog0[31-6*g -: 6];
    end else if (g < SLOTS) begin : g_w1
      assign ops[g] = prog1[31-6*(g-5) -: 6];
    end else begin : g_end
      assign ops[g] = OP_NOP;
    end
  end
  assign curOp = ops[slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
      byteIdx <= '0;
    end else begin
      if (strb.clrCnt) waitCnt <= '0;
      else if (strb.incWait) waitCnt <= waitCnt + 1'b1;
      if (strb.clrCnt) byteIdx <= '0;
      else if (strb.ale || strb.re) byteIdx <= byteIdx + 1'b1;
    end
  end

  assign waitExpired = (waitCnt == waitLim);
  assign addrLast    = (byteIdx == (strb.useRow ? CNT_W'(2) : CNT_W'(1)));
  assign readTotal   = (cntReg == '0) ? CNT_W'(PAGE_BYTES) : cntReg;
  assign readLast    = (byteIdx == readTotal - 1'b1);

  always_comb begin
    nandDout = 8'h00;
    if (strb.cle) begin
      case (strb.cmdSel)
        2'd0:    nandDout = cmdReg[31:24];
        2'd1:    nandDout = cmdReg[23:16];
        2'd2:    nandDout = cmdReg[15:8];
        default: nandDout = cmdReg[7:0];
      endcase
    end else if (strb.ale) begin
      if (strb.useRow) begin
        case (byteIdx[1:0])
          2'd0:    nandDout = rowReg[7:0];
          2'd1:    nandDout = rowReg[15:8];
          default: nandDout = rowReg[23:16];
        endcase
      end else begin
        nandDout = byteIdx[0] ? colReg[15:8] : colReg[7:0];
      end
    end
  end

  assign colBase = BUF_AW'(colReg[BUF_AW-2:0]) + (colReg[31] ? BUF_AW'(PAGE_BYTES) : BUF_AW'(0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufWe   <= 1'b0;
      bufAddr <= '0;
      bufData <= '0;
    end else begin
      bufWe <= strb.re;
      if (strb.re) begin
        bufAddr <= colBase + BUF_AW'(byteIdx);
        bufData <= nandDin;
      end
    end
  end

  // R6: every buffer write is caused by a read strobe one cycle earlier
  a_r6_buf_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> $past(strb.re));

  // R8: a timeout never appears without completion
  a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statTo) |-> statDone);

  // R5: no address burst runs past its third byte
  a_r5_addr_index: assert property (@(posedge clk) disable iff (!rstN)
    strb.ale |-> byteIdx <= CNT_W'(2));
endmodule

// File: rtl/nand_op_sequencer.sv
module nand_op_sequencer
  import nseq_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int WAIT_W     = 16,
  localparam int BUF_AW    = $clog2(PAGE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandRe,
  output logic [7:0]        nandDout,
  input  logic [7:0]        nandDin,
  input  logic              nandRdy,
  output logic              bufWe,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [7:0]        bufData
);
  seqStrobe_t strb;
  logic [2:0] slot;
  logic [5:0] curOp;
  logic       startReq, waitExpired, addrLast, readLast;

  nseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .curOp(curOp),
    .nandRdy(nandRdy), .waitExpired(waitExpired), .addrLast(addrLast),
    .readLast(readLast), .slot(slot), .strb(strb)
  );

  nseq_dpath #(.PAGE_BYTES(PAGE_BYTES), .WAIT_W(WAIT_W)) i_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb), .slot(slot),
    .curOp(curOp), .startReq(startReq), .waitExpired(waitExpired),
    .addrLast(addrLast), .readLast(readLast), .nandDout(nandDout),
    .nandDin(nandDin), .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  assign nandCle = strb.cle;
  assign nandAle = strb.ale;
  assign nandRe  = strb.re;
endmodule

// File: tb/test_nand_op_sequencer.sv
module test_nand_op_sequencer;
  localparam int PAGE = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        nandCle, nandAle, nandRe, bufWe;
  logic [7:0]  nandDout, nandDin, bufData;
  logic        nandRdy = 1'b1;
  logic [6:0]  bufAddr;

  int total = 0;
  int bad = 0;
  int cleN = 0, aleN = 0, rdN = 0;
  int cleBase = 0, aleBase = 0, rdBase = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] cleByte [1024];
  logic [7:0] aleByte [1024];
  logic [7:0] bufMem [128];

  always #5 clk = ~clk;

  nand_op_sequencer i_nand_op_sequencer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .nandCle(nandCle),
    .nandAle(nandAle), .nandRe(nandRe), .nandDout(nandDout), .nandDin(nandDin),
    .nandRdy(nandRdy), .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  assign nandDin = seed + 8'(rdN - rdBase);

  always @(posedge clk) begin
    if (rstN) begin
      if (nandCle) begin cleByte[cleN % 1024] <= nandDout; cleN <= cleN + 1; end
      if (nandAle) begin aleByte[aleN % 1024] <= nandDout; aleN <= aleN + 1; end
      if (nandRe) rdN <= rdN + 1;
      if (bufWe) bufMem[bufAddr] <= bufData;
    end
  end

  function automatic logic [31:0] mk0(input logic [5:0] a, b, c, d, e);
    return {a, b, c, d, e, 2'b00};
  endfunction
  function automatic logic [31:0] mk1(input logic [5:0] f, g);
    return {f, g, 20'd0};
  endfunction

  typedef struct packed {
    logic [31:0] p0;
    logic [31:0] p1;
    logic [7:0]  count;
    logic [7:0]  expCle;
    logic [7:0]  expAle;
    logic [7:0]  expRe;
    logic [7:0]  firstCle;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{mk0(6'h11, 6'h01, 6'h05, 6'h0A, 6'h1B), 32'd0, 8'd8, 8'd2, 8'd5, 8'd8, 8'h11},
    '{mk0(6'h11, 6'h01, 6'h05, 6'h1B, 6'h00), 32'd0, 8'd4, 8'd1, 8'd5, 8'd4, 8'h11},
    '{mk0(6'h0C, 6'h00, 6'h09, 6'h09, 6'h09), 32'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'h44},
    '{mk0(6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h01), mk1(6'h05, 6'h1B), 8'd0, 8'd4, 8'd5, 8'd64, 8'h11},
    '{mk0(6'h3F, 6'h02, 6'h0B, 6'h00, 6'h00), 32'd0, 8'd2, 8'd1, 8'd0, 8'd0, 8'h33}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic markLogs();
    cleBase = cleN; aleBase = aleN; rdBase = rdN;
  endtask

  task automatic waitDone(output logic ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      regRead(4'd7, s);
      ok = s[31];
    end
  endtask

  task automatic setup(input logic [31:0] p0, p1, cnt, col);
    regWrite(4'd7, 32'h8800_0000);
    regWrite(4'd4, p0);
    regWrite(4'd5, p1);
    regWrite(4'd3, cnt);
    regWrite(4'd2, col);
    markLogs();
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic ok;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 strobes low in reset", {61'd0, nandCle, nandAle, nandRe}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    regRead(4'd7, s);
    chk("R1 status after reset", s, 32'd0);
    chk("R1 strobes idle after reset", {61'd0, nandCle, nandAle, nandRe}, 64'd0);

    regWrite(4'd0, 32'h1122_3344);
    regWrite(4'd1, 32'h0000_0003);
    regWrite(4'd8, 32'd1000);

    // R2 R3 R5 R6 R11: table of programs
    foreach (VECS[v]) begin
      setup(VECS[v].p0, VECS[v].p1, {24'd0, VECS[v].count}, 32'd0);
      regWrite(4'd6, 32'h8000_0000);
      waitDone(ok);
      chk($sformatf("R2 vec%0d done", v), {63'd0, ok}, 64'd1);
      chk($sformatf("R3 vec%0d cle count", v), 64'(cleN - cleBase), 64'(VECS[v].expCle));
      chk($sformatf("R3 vec%0d first cle", v), 64'(cleByte[cleBase]), 64'(VECS[v].firstCle));
      chk($sformatf("R5 vec%0d ale count", v), 64'(aleN - aleBase), 64'(VECS[v].expAle));
      chk($sformatf("R6 vec%0d read count", v), 64'(rdN - rdBase), 64'(VECS[v].expRe));
      regRead(4'd7, s);
      chk($sformatf("R8 vec%0d no timeout", v), {63'd0, s[27]}, 64'd0);
    end

    // R5: address byte order
    regWrite(4'd1, 32'h00AB_CDEF);
    setup(mk0(6'h01, 6'h05, 6'h00, 6'h00, 6'h00), 32'd0, 32'd1, 32'h0000_1234);
    regWrite(4'd6, 32'h8000_0000);
    waitDone(ok);
    chk("R5 address bytes", {24'd0, aleByte[aleBase], aleByte[aleBase+1], aleByte[aleBase+2],
        aleByte[aleBase+3], aleByte[aleBase+4]}, 64'h34_12_EF_CD_AB);

    // R6: spare-area buffer placement
    seed = 8'h50;
    setup(mk0(6'h1B, 6'h00, 6'h00, 6'h00, 6'h00), 32'd0, 32'd3, 32'h8000_0005);
    regWrite(4'd6, 32'h8000_0000);
    waitDone(ok);
    @(negedge clk);
    chk("R6 spare buffer bytes", {40'd0, bufMem[69], bufMem[70], bufMem[71]}, 64'h50_51_52);

    // R7: exact completion cycle
    setup(mk0(6'h09, 6'h00, 6'h00, 6'h00, 6'h00), 32'd0, 32'd1, 32'd0);
    regWrite(4'd6, 32'h8000_0000);
    @(negedge clk);
    @(negedge clk);
    regRead(4'd7, s);
    chk("R7 done not yet after 2 edges", {63'd0, s[31]}, 64'd0);
    @(negedge clk);
    regRead(4'd7, s);
    chk("R7 done after 3 edges", {63'd0, s[31]}, 64'd1);

    // R4: wait for ready before command
    nandRdy = 1'b0;
    setup(mk0(6'h12, 6'h00, 6'h00, 6'h00, 6'h00), 32'd0, 32'd1, 32'd0);
    regWrite(4'd6, 32'h8000_0000);
    repeat (20) @(negedge clk);
    chk("R4 no cle while busy", 64'(cleN - cleBase), 64'd0);
    nandRdy = 1'b1;
    waitDone(ok);
    chk("R4 cle after ready", 64'(cleN - cleBase), 64'd1);
    chk("R4 cle byte 1", 64'(cleByte[cleBase]), 64'h22);

    // R8: timeout
    nandRdy = 1'b0;
    regWrite(4'd8, 32'd5);
    setup(mk0(6'h11, 6'h01, 6'h00, 6'h00, 6'h00), 32'd0, 32'd1, 32'd0);
    regWrite(4'd6, 32'h8000_0000);
    waitDone(ok);
    regRead(4'd7, s);
    chk("R8 timeout and done", {62'd0, s[31], s[27]}, 64'd3);
    nandRdy = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no strobes after stop", 64'((cleN - cleBase) + (aleN - aleBase)), 64'd0);

    // R9: write-one-to-clear
    regRead(4'd7, s);
    chk("R9 bits 25 24 zero", {62'd0, s[25], s[24]}, 64'd0);
    regWrite(4'd7, 32'h0800_0000);
    regRead(4'd7, s);
    chk("R9 clear timeout only", {62'd0, s[31], s[27]}, 64'd2);
    regWrite(4'd7, 32'h8000_0000);
    regRead(4'd7, s);
    chk("R9 clear done", s, 32'd0);

    // R10: start while running is ignored
    regWrite(4'd8, 32'd1000);
    setup(mk0(6'h1B, 6'h00, 6'h00, 6'h00, 6'h00), 32'd0, 32'd32, 32'd0);
    regWrite(4'd6, 32'h8000_0000);
    repeat (8) @(negedge clk);
    regWrite(4'd6, 32'h8000_0000);
    waitDone(ok);
    repeat (10) @(negedge clk);
    chk("R10 read count unchanged by restart", 64'(rdN - rdBase), 64'd32);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule